// File: doc/BRIEF.md
# Clock-Bring-Up Register Access Gate

This block sits behind a byte-oriented control port. A serial front end presents a burst as a start strobe carrying a 16-bit address, one or more byte write or byte read strobes, and a stop strobe. The block decides which of these accesses may take effect while the core clock is being brought up. It holds a clock-setup register, a six-byte PLL-setup register, and a digital power-enable register. It models PLL lock acquisition with a cycle counter and drives a gated core-clock enable to downstream logic. Accesses to any other address pass to a downstream register/memory bus. They pass only once the clocks are up and the memory and core power enables are on.

Every byte of a burst targets the burst's start address. The one exception is a burst to the PLL-setup register, which consumes six consecutive bytes. Byte strobes that arrive outside a burst, or in the same cycle as a start or stop strobe, have no effect. A read returns its byte one cycle after the read strobe.

Top module: `ctlgate_top`

## Requirements
- R1: After reset, all of the following read zero: the clock-setup register, the PLL-setup register, the power-enable register, lock, the core-clock enable and both sticky flags.
- R2: The clock-setup register is at address 0x4000. Bit 0 is the core enable. Bits [2:1] hold the master-clock ratio (00 = 256x, 01 = 512x, 10 = 768x, 11 = 1024x), which appears on `mclk_ratio`. A read returns {5'b0, ratio, enable}.
- R3: `core_clk_en` is 1 only when the core enable is 1 and either the PLL is bypassed (PLL-setup bit 0 = 0) or lock is 1.
- R4: The PLL-setup register is at 0x4002 and takes effect only when a single burst writes all six bytes. The first byte is bits [47:40] and the last byte is bits [7:0]. Bit 0 enables the PLL. Bytes after the sixth, in the same burst, are ignored. A read burst returns the bytes in the same order and returns 0 after the sixth byte.
- R5: A PLL-setup burst that ends after one to five bytes, by a stop strobe or by a new start strobe, is discarded. It leaves the previous contents unchanged and sets the sticky `burst_err` flag.
- R6: Committing the register with bit 0 = 1 restarts acquisition, and lock rises exactly LOCK_CYCLES clock cycles after the committing write. Committing with bit 0 = 0 clears lock at once. Bit 1 is read-only: writes to it are dropped, and reads of it return lock.
- R7: Until both the core enable and lock are 1, only 0x4000 and 0x4002 are accessible. A write to any other address is dropped, a read of one returns 0x00, and either access sets the sticky `viol_flag`.
- R8: Reading 0x4000 clears both `viol_flag` and `burst_err`.
- R9: The power-enable register is at 0x4080. Downstream accesses (any address other than 0x4000, 0x4002 and 0x4080) go out on `ext_wr`/`ext_rd` in the strobe cycle only if the clocks are up and power bits 6 (memory) and 0 (core) are both 1. Otherwise the access is dropped, a read returns 0, and `viol_flag` is set.
- R10: While `pdn` is high at a clock edge, every register, lock, both flags and `core_clk_en` return to their reset values.
- R11: `cp_rvalid` pulses for one cycle, one cycle after each accepted read strobe, and `cp_rdata` holds the byte read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pdn | input | 1 | Power-down, synchronous clear, active high |
| cp_start | input | 1 | Burst start strobe |
| cp_addr | input | 16 | Burst start address, sampled with cp_start |
| cp_stop | input | 1 | Burst end strobe |
| cp_wr | input | 1 | Byte write strobe |
| cp_wdata | input | 8 | Write byte |
| cp_rd | input | 1 | Byte read strobe |
| cp_rdata | output | 8 | Read byte |
| cp_rvalid | output | 1 | Read byte valid |
| ext_wr | output | 1 | Downstream write strobe |
| ext_rd | output | 1 | Downstream read strobe |
| ext_addr | output | 16 | Downstream address |
| ext_wdata | output | 8 | Downstream write byte |
| ext_rdata | input | 8 | Downstream read byte, sampled in the ext_rd cycle |
| core_clk_en | output | 1 | Gated core-clock enable |
| mclk_ratio | output | 2 | Master-clock ratio selection |
| pll_cfg | output | 8*PLL_BYTES | PLL-setup register contents (bit 1 stored as 0) |
| pll_locked | output | 1 | Lock status |
| dig_pwr | output | 8 | Power-enable register |
| viol_flag | output | 1 | Sticky access-violation flag |
| burst_err | output | 1 | Sticky incomplete-burst flag |

## Verification
The bench cuts PLL bursts short in two ways: with a stop strobe after three bytes, and with a new start after two. A design that committed partial data would show altered `pll_cfg`, and one that missed the abort would leave `burst_err` low. It checks lock one cycle before and exactly at LOCK_CYCLES. An off-by-one counter fails one of the two samples. It also sends a seventh byte to a completed burst, which would corrupt the register if the byte count wrapped. It probes the access gate three ways: before lock, with only one of the two power bits set, and after a bypass write drops lock. A design that let any of these accesses through would raise `ext_wr` or change `dig_pwr` without setting `viol_flag`.

// File: rtl/ctlgate_pkg.sv
package ctlgate_pkg;

  localparam int ADDR_W = 16;

  localparam logic [ADDR_W-1:0] CLK_REG_ADDR = 16'h4000;
  localparam logic [ADDR_W-1:0] PLL_REG_ADDR = 16'h4002;
  localparam logic [ADDR_W-1:0] PWR_REG_ADDR = 16'h4080;

  localparam int PWR_MEM_BIT  = 6;
  localparam int PWR_CORE_BIT = 0;

  typedef enum logic [1:0] {
    TGT_CLK,
    TGT_PLL,
    TGT_PWR,
    TGT_EXT
  } tgt_e;

  function automatic tgt_e target_of(input logic [ADDR_W-1:0] a);
    if (a == CLK_REG_ADDR)      return TGT_CLK;
    else if (a == PLL_REG_ADDR) return TGT_PLL;
    else if (a == PWR_REG_ADDR) return TGT_PWR;
    else                        return TGT_EXT;
  endfunction

  function automatic logic [7:0] clk_ctrl_image(input logic en, input logic [1:0] ratio);
    return {5'b0, ratio, en};
  endfunction

  function automatic logic mem_path_on(input logic [7:0] pwr);
    return pwr[PWR_MEM_BIT] & pwr[PWR_CORE_BIT];
  endfunction

  function automatic logic core_gate(input logic en, input logic pll_on, input logic locked);
    return en & (~pll_on | locked);
  endfunction

endpackage

// File: rtl/ctlgate_access_gate.sv
module ctlgate_access_gate
  import ctlgate_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic              core_en,
  input  logic              locked,
  input  logic [7:0]        pwr,
  output tgt_e              tgt,
  output logic              permit
);

  logic clocks_up;
  assign clocks_up = core_en & locked;

  always_comb begin
    tgt = target_of(addr);
    unique case (tgt)
      TGT_CLK, TGT_PLL: permit = 1'b1;
      TGT_PWR:          permit = clocks_up;
      default:          permit = clocks_up & mem_path_on(pwr);
    endcase
  end

endmodule

// File: rtl/ctlgate_pll_shadow.sv
module ctlgate_pll_shadow #(
  parameter int BYTES       = 6,
  parameter int LOCK_CYCLES = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               burst_edge,
  input  logic               wr_byte,
  input  logic [7:0]         wdata,
  output logic [8*BYTES-1:0] cfg,
  output logic               locked,
  output logic               commit_evt,
  output logic               abort_evt
);

  localparam int W  = 8 * BYTES;
  localparam int IW = $clog2(BYTES + 1);
  localparam int CW = $clog2(LOCK_CYCLES + 1);
  localparam logic [IW-1:0] LAST = IW'(BYTES - 1);
  localparam logic [IW-1:0] FULL = IW'(BYTES);
  localparam logic [CW-1:0] CNT_END = CW'(LOCK_CYCLES - 1);

  logic [IW-1:0] idx;
  logic [W-1:0]  stage, stage_next, commit_word;
  logic          acq;
  logic [CW-1:0] cnt;

  assign commit_evt = wr_byte && (idx == LAST);
  assign abort_evt  = burst_edge && (idx != '0) && (idx != FULL);

  // byte idx of the burst lands at slice BYTES-1-idx (first byte is the top)
  always_comb begin
    stage_next = stage;
    for (int b = 0; b < BYTES; b++) begin
      if (wr_byte && idx == IW'(BYTES - 1 - b)) stage_next[8*b +: 8] = wdata;
    end
    commit_word    = stage_next;
    commit_word[1] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx    <= '0;
      stage  <= '0;
      cfg    <= '0;
      locked <= 1'b0;
      acq    <= 1'b0;
      cnt    <= '0;
    end else if (clr) begin
      idx    <= '0;
      stage  <= '0;
      cfg    <= '0;
      locked <= 1'b0;
      acq    <= 1'b0;
      cnt    <= '0;
    end else begin
      if (burst_edge) begin
        idx <= '0;
      end else if (wr_byte && idx != FULL) begin
        idx   <= idx + 1'b1;
        stage <= stage_next;
      end
      if (commit_evt) begin
        cfg    <= commit_word;
        locked <= 1'b0;
        acq    <= commit_word[0];
        cnt    <= '0;
      end else if (acq) begin
        if (cnt == CNT_END) begin
          locked <= 1'b1;
          acq    <= 1'b0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/ctlgate_top.sv
module ctlgate_top
  import ctlgate_pkg::*;
#(
  parameter int PLL_BYTES   = 6,
  parameter int LOCK_CYCLES = 64
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   pdn,
  input  logic                   cp_start,
  input  logic [15:0]            cp_addr,
  input  logic                   cp_stop,
  input  logic                   cp_wr,
  input  logic [7:0]             cp_wdata,
  input  logic                   cp_rd,
  output logic [7:0]             cp_rdata,
  output logic                   cp_rvalid,
  output logic                   ext_wr,
  output logic                   ext_rd,
  output logic [15:0]            ext_addr,
  output logic [7:0]             ext_wdata,
  input  logic [7:0]             ext_rdata,
  output logic                   core_clk_en,
  output logic [1:0]             mclk_ratio,
  output logic [8*PLL_BYTES-1:0] pll_cfg,
  output logic                   pll_locked,
  output logic [7:0]             dig_pwr,
  output logic                   viol_flag,
  output logic                   burst_err
);

  localparam int RW = $clog2(PLL_BYTES + 1);
  localparam logic [RW-1:0] RPOS_FULL = RW'(PLL_BYTES);
  localparam logic [RW-1:0] RPOS_LAST = RW'(PLL_BYTES - 1);

  logic              active;
  logic [ADDR_W-1:0] base_addr;
  logic [RW-1:0]     rpos;
  logic              core_en;
  logic [1:0]        ratio;
  tgt_e              tgt;
  logic              permit;

  // named internal events
  logic wr_evt, rd_evt, deny_evt, clk_rd_evt, pll_wr_evt, commit_evt, abort_evt;
  logic [7:0] rd_byte;

  assign wr_evt     = cp_wr && active && !cp_start && !cp_stop;
  assign rd_evt     = cp_rd && active && !cp_start && !cp_stop;
  assign deny_evt   = (wr_evt || rd_evt) && !permit;
  assign clk_rd_evt = rd_evt && (tgt == TGT_CLK);
  assign pll_wr_evt = wr_evt && (tgt == TGT_PLL);

  ctlgate_access_gate u_gate (
    .addr    (base_addr),
    .core_en (core_en),
    .locked  (pll_locked),
    .pwr     (dig_pwr),
    .tgt     (tgt),
    .permit  (permit)
  );

  ctlgate_pll_shadow #(
    .BYTES       (PLL_BYTES),
    .LOCK_CYCLES (LOCK_CYCLES)
  ) u_pll (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (pdn),
    .burst_edge (cp_start || cp_stop),
    .wr_byte    (pll_wr_evt),
    .wdata      (cp_wdata),
    .cfg        (pll_cfg),
    .locked     (pll_locked),
    .commit_evt (commit_evt),
    .abort_evt  (abort_evt)
  );

  assign ext_wr      = wr_evt && (tgt == TGT_EXT) && permit;
  assign ext_rd      = rd_evt && (tgt == TGT_EXT) && permit;
  assign ext_addr    = base_addr;
  assign ext_wdata   = cp_wdata;
  assign mclk_ratio  = ratio;
  assign core_clk_en = core_gate(core_en, pll_cfg[0], pll_locked);

  always_comb begin
    rd_byte = 8'h00;
    if (permit) begin
      unique case (tgt)
        TGT_CLK: rd_byte = clk_ctrl_image(core_en, ratio);
        TGT_PWR: rd_byte = dig_pwr;
        TGT_EXT: rd_byte = ext_rdata;
        default: begin
          for (int b = 0; b < PLL_BYTES; b++) begin
            if (rpos == RW'(b)) rd_byte = pll_cfg[8*(PLL_BYTES-1-b) +: 8];
          end
          if (rpos == RPOS_LAST) rd_byte[1] = pll_locked;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active    <= 1'b0;
      base_addr <= '0;
      rpos      <= '0;
      core_en   <= 1'b0;
      ratio     <= 2'b00;
      dig_pwr   <= 8'h00;
      viol_flag <= 1'b0;
      burst_err <= 1'b0;
      cp_rdata  <= 8'h00;
      cp_rvalid <= 1'b0;
    end else if (pdn) begin
      active    <= 1'b0;
      base_addr <= '0;
      rpos      <= '0;
      core_en   <= 1'b0;
      ratio     <= 2'b00;
      dig_pwr   <= 8'h00;
      viol_flag <= 1'b0;
      burst_err <= 1'b0;
      cp_rdata  <= 8'h00;
      cp_rvalid <= 1'b0;
    end else begin
      cp_rvalid <= rd_evt;
      if (rd_evt) cp_rdata <= rd_byte;
      if (cp_start) begin
        active    <= 1'b1;
        base_addr <= cp_addr;
        rpos      <= '0;
      end else if (cp_stop) begin
        active <= 1'b0;
      end
      if (rd_evt && tgt == TGT_PLL && rpos != RPOS_FULL) rpos <= rpos + 1'b1;
      if (wr_evt && permit) begin
        if (tgt == TGT_CLK) begin
          core_en <= cp_wdata[0];
          ratio   <= cp_wdata[2:1];
        end else if (tgt == TGT_PWR) begin
          dig_pwr <= cp_wdata;
        end
      end
      if (clk_rd_evt) begin
        viol_flag <= 1'b0;
        burst_err <= 1'b0;
      end
      if (deny_evt)  viol_flag <= 1'b1;
      if (abort_evt) burst_err <= 1'b1;
    end
  end

endmodule

// File: rtl/ctlgate_checker.sv
module ctlgate_checker #(
  parameter int CFG_W = 48
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pdn,
  input logic             cp_rd,
  input logic             cp_rvalid,
  input logic             ext_wr,
  input logic             ext_rd,
  input logic             core_en,
  input logic             core_clk_en,
  input logic [CFG_W-1:0] pll_cfg,
  input logic             pll_locked,
  input logic [7:0]       dig_pwr,
  input logic             viol_flag,
  input logic             burst_err
);

  assert_clk_off_while_acquiring_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pll_cfg[0] && !pll_locked) |-> !core_clk_en);

  assert_abort_keeps_cfg_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(burst_err) |-> $stable(pll_cfg));

  assert_lock_needs_pll_on_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pll_locked |-> pll_cfg[0]);

  assert_ext_needs_clocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_wr || ext_rd) |-> (core_en && pll_locked));

  assert_ext_needs_power_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_wr || ext_rd) |-> (dig_pwr[6] && dig_pwr[0]));

  assert_ext_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ext_wr, ext_rd}));

  assert_pdn_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pdn |=> (!core_clk_en && !pll_locked && !viol_flag && !burst_err && dig_pwr == 8'h00));

  assert_rvalid_after_rd_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cp_rvalid |-> $past(cp_rd));

endmodule

bind ctlgate_top ctlgate_checker #(.CFG_W(8*PLL_BYTES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .pdn         (pdn),
  .cp_rd       (cp_rd),
  .cp_rvalid   (cp_rvalid),
  .ext_wr      (ext_wr),
  .ext_rd      (ext_rd),
  .core_en     (core_en),
  .core_clk_en (core_clk_en),
  .pll_cfg     (pll_cfg),
  .pll_locked  (pll_locked),
  .dig_pwr     (dig_pwr),
  .viol_flag   (viol_flag),
  .burst_err   (burst_err)
);

// File: tb/ctlgate_top_tb.sv
`timescale 1ns/1ps
module ctlgate_top_tb;

  localparam int LOCK = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pdn = 1'b0;
  logic        cp_start = 1'b0, cp_stop = 1'b0, cp_wr = 1'b0, cp_rd = 1'b0;
  logic [15:0] cp_addr = '0;
  logic [7:0]  cp_wdata = '0;
  logic [7:0]  cp_rdata;
  logic        cp_rvalid, ext_wr, ext_rd;
  logic [15:0] ext_addr;
  logic [7:0]  ext_wdata, ext_rdata;
  logic        core_clk_en, pll_locked, viol_flag, burst_err;
  logic [1:0]  mclk_ratio;
  logic [47:0] pll_cfg;
  logic [7:0]  dig_pwr;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #2 clk = ~clk;

  assign ext_rdata = ext_addr[7:0] ^ 8'hA5;

  ctlgate_top #(.PLL_BYTES(6), .LOCK_CYCLES(LOCK)) u_dut (
    .clk(clk), .rst_n(rst_n), .pdn(pdn),
    .cp_start(cp_start), .cp_addr(cp_addr), .cp_stop(cp_stop),
    .cp_wr(cp_wr), .cp_wdata(cp_wdata), .cp_rd(cp_rd),
    .cp_rdata(cp_rdata), .cp_rvalid(cp_rvalid),
    .ext_wr(ext_wr), .ext_rd(ext_rd), .ext_addr(ext_addr),
    .ext_wdata(ext_wdata), .ext_rdata(ext_rdata),
    .core_clk_en(core_clk_en), .mclk_ratio(mclk_ratio),
    .pll_cfg(pll_cfg), .pll_locked(pll_locked), .dig_pwr(dig_pwr),
    .viol_flag(viol_flag), .burst_err(burst_err)
  );

  // downstream write observer
  int          ext_wr_n = 0;
  logic [15:0] ext_last_addr = '0;
  logic [7:0]  ext_last_data = '0;
  always @(posedge clk) begin
    if (ext_wr) begin
      ext_wr_n      = ext_wr_n + 1;
      ext_last_addr = ext_addr;
      ext_last_data = ext_wdata;
    end
  end

  // scoreboard for read data
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always @(negedge clk) begin : monitor
    logic [7:0] e;
    string      t;
    if (rst_n && cp_rvalid) begin
      n_tests++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R11: unexpected read byte actual %0h expected none", cp_rdata);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (cp_rdata !== e) begin
          n_fail++;
          $display("FAIL %s: read actual %0h expected %0h", t, cp_rdata, e);
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic do_start(input logic [15:0] a);
    cp_start = 1'b1; cp_addr = a; tick(); cp_start = 1'b0;
  endtask

  task automatic do_stop();
    cp_stop = 1'b1; tick(); cp_stop = 1'b0;
  endtask

  task automatic do_wr(input logic [7:0] b);
    cp_wr = 1'b1; cp_wdata = b; tick(); cp_wr = 1'b0;
  endtask

  task automatic do_rd(input logic [7:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    cp_rd = 1'b1; tick(); cp_rd = 1'b0;
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tick();

    // R1 reset state
    chk("R1 core_clk_en", core_clk_en, 0);
    chk("R1 lock", pll_locked, 0);
    chk("R1 flags", {viol_flag, burst_err}, 0);
    chk("R1 pll_cfg", pll_cfg, 0);
    chk("R1 ratio/pwr", {mclk_ratio, dig_pwr}, 0);

    // R7 gate closed before lock: write/read of 0x4080 refused
    do_start(16'h4080);
    do_wr(8'h41);
    chk("R7 viol on denied write", viol_flag, 1);
    chk("R7 denied write dropped", dig_pwr, 8'h00);
    do_rd(8'h00, "R7 denied read zero");
    do_stop();
    // R8 clock-setup read clears flag; R2 reset image
    do_start(16'h4000);
    do_rd(8'h00, "R2 clock reg reset image");
    chk("R8 viol cleared", viol_flag, 0);
    // R2 write ratio 768x (10) + enable
    do_wr(8'h05);
    chk("R2 ratio field", mclk_ratio, 2'b10);
    chk("R3 bypass core clock on", core_clk_en, 1);
    do_rd(8'h05, "R2 clock reg readback");
    do_stop();

    // R5 burst stopped after three bytes
    do_start(16'h4002);
    do_wr(8'h11); do_wr(8'h22); do_wr(8'h33);
    do_stop();
    chk("R5 burst_err on short burst", burst_err, 1);
    chk("R5 cfg kept", pll_cfg, 0);
    do_start(16'h4000);
    do_rd(8'h05, "R8 clear read");
    do_stop();
    chk("R8 burst_err cleared", burst_err, 0);

    // R4/R6 full burst enabling the PLL
    do_start(16'h4002);
    do_wr(8'h12); do_wr(8'h34); do_wr(8'h56); do_wr(8'h78); do_wr(8'h9A);
    do_wr(8'hBF);  // bit1 set by the writer must be dropped
    chk("R4 cfg committed", pll_cfg, 48'h123456789ABD);
    chk("R6 lock low at commit", pll_locked, 0);
    chk("R3 clock off while acquiring", core_clk_en, 0);
    repeat (LOCK - 1) @(posedge clk);
    #1;
    chk("R6 lock low one cycle early", pll_locked, 0);
    tick();
    chk("R6 lock at LOCK_CYCLES", pll_locked, 1);
    chk("R3 clock on after lock", core_clk_en, 1);
    do_wr(8'hFF);
    chk("R4 seventh byte ignored", pll_cfg, 48'h123456789ABD);
    do_stop();
    chk("R5 complete burst no error", burst_err, 0);

    // R4/R6 read burst
    do_start(16'h4002);
    do_rd(8'h12, "R4 byte0");
    do_rd(8'h34, "R4 byte1");
    do_rd(8'h56, "R4 byte2");
    do_rd(8'h78, "R4 byte3");
    do_rd(8'h9A, "R4 byte4");
    do_rd(8'hBF, "R6 lock bit in last byte");
    do_rd(8'h00, "R4 past end");
    do_stop();

    // R9 power bits
    do_start(16'h4080);
    do_wr(8'h01);
    do_stop();
    chk("R9 pwr written after lock", dig_pwr, 8'h01);
    do_start(16'h0123);
    do_wr(8'h77);
    chk("R9 ext denied without mem bit", ext_wr_n, 0);
    chk("R9 viol without mem bit", viol_flag, 1);
    do_stop();
    do_start(16'h4000);
    do_rd(8'h05, "R8 clear read 2");
    do_stop();
    do_start(16'h4080);
    do_wr(8'h41);
    do_stop();
    do_start(16'h0123);
    do_wr(8'h77);
    chk("R9 ext write issued", ext_wr_n, 1);
    chk("R9 ext addr/data", {ext_last_addr, ext_last_data}, {16'h0123, 8'h77});
    do_rd(8'h86, "R9 ext read data");
    do_stop();
    chk("R9 no viol when allowed", viol_flag, 0);
    do_start(16'h4080);
    do_rd(8'h41, "R9 pwr readback");
    do_stop();

    // R6 bypass commit clears lock, gate closes again
    do_start(16'h4002);
    for (int i = 0; i < 6; i++) do_wr(8'h00);
    do_stop();
    chk("R6 bypass clears lock", pll_locked, 0);
    chk("R3 bypass clock on", core_clk_en, 1);
    do_start(16'h4080);
    do_wr(8'h00);
    chk("R7 gate closed after bypass", viol_flag, 1);
    chk("R7 pwr unchanged", dig_pwr, 8'h41);
    do_stop();

    // R5 burst cut by new start
    do_start(16'h4002);
    do_wr(8'hAA); do_wr(8'hBB);
    do_start(16'h4000);
    chk("R5 abort by restart", burst_err, 1);
    chk("R5 cfg kept after restart", pll_cfg, 0);
    do_rd(8'h05, "R8 clear read 3");
    do_stop();
    chk("R8 both flags cleared", {viol_flag, burst_err}, 0);

    // R10 power-down
    do_start(16'h4002);
    for (int i = 0; i < 5; i++) do_wr(8'h00);
    do_wr(8'h01);
    do_stop();
    pdn = 1'b1; tick(); pdn = 1'b0;
    chk("R10 cleared regs", {mclk_ratio, dig_pwr, pll_cfg}, 0);
    chk("R10 cleared state", {core_clk_en, pll_locked, viol_flag, burst_err}, 0);
    repeat (LOCK + 2) tick();
    chk("R10 no lock after pdn", pll_locked, 0);
    do_start(16'h4000);
    do_rd(8'h00, "R10 clock reg default");
    do_stop();

    tick();
    chk("R11 all reads answered", exp_q.size(), 0);
    done = 1;
    summary();
    $finish;
  end

endmodule